// File: doc/BRIEF.md
# Edge-Safe PWM Compare Unit

This block produces pulse-width modulated outputs from one shared up-counter. The counter starts at zero, steps once per enabled clock up to a period register value P, and then returns to zero, so one period lasts P+1 clocks. Each channel compares the count against its own compare value M. The channel's mode decides whether the output drops or rises at that match, or whether the output simply flips at every wrap of the counter.

The two extremes of the duty range are exact. A compare value of zero means that the match event and the wrap event fall on the same count. In that case the match event always wins, so the output stays flat and never pulses. A compare value above P never matches, so the level set at the wrap is held for the whole period. Compare and mode writes are staged and take effect only at the next wrap, so a running period is never cut short. The period register takes effect at once.

Typical use: program the period, the compare value and the mode of each channel, pulse the clear, then hold the run enable high.

Top module: `cmp_pwm_unit`

## Requirements
- R1: While running, the count rises by one per clock. On any step where the count is greater than or equal to P, the count returns to 0. The period is therefore P+1 clocks. A write to P is used from the next clock on.
- R2: In mode 0 (high-first), the output is high while the count is 0 to M-1 and low while the count is M to P, for a duty of M/(P+1).
- R3: In mode 1 (low-first), the output is low while the count is 0 to M-1 and high while the count is M to P.
- R4: With M greater than P, mode 0 stays high and mode 1 stays low through every full period.
- R5: With M equal to 0, mode 0 stays low and mode 1 stays high through every full period, with no one-clock pulse at the wrap. This holds because the compare event beats the wrap event.
- R6: In mode 2 (toggle), the output inverts at each wrap, which gives a square wave of 2(P+1) clocks. Mode 3 holds the output.
- R7: Compare values written with cmp_we_i[i] and modes written with mode_we_i[i] are held in a staging register. They take effect only at the next wrap, or at a clear.
- R8: A clear sets the count to 0, sets every output low and loads the staged values. After reset, every output is low.
- R9: While the run enable is low, with no clear, the count and the outputs hold.
- R10: With P equal to 0, the count stays at 0. Mode 0 then stays low if M is 0 and high otherwise. Mode 1 stays high if M is 0 and low otherwise. Mode 2 holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of counter and outputs |
| run_i | input | 1 | Counter run enable |
| per_we_i | input | 1 | Period register write strobe |
| per_data_i | input | CNT_W | Period value P |
| cmp_we_i | input | NUM_CH | Per-channel compare write strobe |
| cmp_data_i | input | CNT_W | Compare value M (shared bus) |
| mode_we_i | input | NUM_CH | Per-channel mode write strobe |
| mode_data_i | input | 2 | Mode code (0 high-first, 1 low-first, 2 toggle, 3 hold) |
| pwm_o | output | NUM_CH | Channel outputs |

## Verification
The hardest case to reach is the clock where the match event and the wrap event fall on the same count. A second hard case is the clock where a staged value is loaded at the same edge that it is first used. The stimulus reaches these by writing M=0, and M values above P, in the middle of a period. It then steps the counter to the wrap, so the new value and the coincident events meet on the same edge. It also drives P to 0, which forces that coincidence on every clock. A per-cycle scoreboard flags any one-clock pulse at those edges, and duty counts over full periods confirm the steady levels.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef enum logic [1:0] {
    OM_CLR_AT_CMP = 2'd0,
    OM_SET_AT_CMP = 2'd1,
    OM_TOGGLE     = 2'd2,
    OM_HOLD       = 2'd3
  } out_mode_e;

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] per_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic [CNT_W-1:0] per_o,
  output logic             step_o,
  output logic             wrap_o,
  output logic             per_zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] per_q, per_d;
  logic             step;
  logic             wrap;

  assign step = run_i & ~clr_i;
  assign wrap = step & (cnt_q >= per_q);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (step) begin
      if (wrap) cnt_d = '0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_comb begin
    per_d = per_q;
    if (per_we_i) per_d = per_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_nxt_o  = cnt_d;
  assign per_o      = per_q;
  assign step_o     = step;
  assign wrap_o     = wrap;
  assign per_zero_o = (per_q == '0);

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             wrap_i,
  input  logic             per_zero_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_data_i,
  input  logic             mode_we_i,
  input  logic [1:0]       mode_data_i,
  output logic             pwm_o,
  output logic [CNT_W-1:0] cmp_act_o,
  output logic [1:0]       mode_act_o
);

  import pwm_pkg::*;

  logic [CNT_W-1:0] cmp_sh_q, cmp_sh_d;
  logic [CNT_W-1:0] cmp_act_q, cmp_act_d;
  out_mode_e        mode_sh_q, mode_sh_d;
  out_mode_e        mode_act_q, mode_act_d;
  logic             out_q, out_d;
  logic             load;
  logic [CNT_W-1:0] cmp_use;
  out_mode_e        mode_use;
  logic             hit_cmp;

  // staging registers
  always_comb begin
    cmp_sh_d  = cmp_sh_q;
    mode_sh_d = mode_sh_q;
    if (cmp_we_i)  cmp_sh_d  = cmp_data_i;
    if (mode_we_i) mode_sh_d = out_mode_e'(mode_data_i);
  end

  // active values swap in at a wrap or a clear
  assign load = clr_i | wrap_i;

  always_comb begin
    cmp_act_d  = cmp_act_q;
    mode_act_d = mode_act_q;
    if (load) begin
      cmp_act_d  = cmp_sh_q;
      mode_act_d = mode_sh_q;
    end
  end

  // the count entered at a wrap belongs to the new period
  assign cmp_use  = wrap_i ? cmp_sh_q  : cmp_act_q;
  assign mode_use = wrap_i ? mode_sh_q : mode_act_q;
  assign hit_cmp  = (cnt_nxt_i == cmp_use);

  always_comb begin
    out_d = out_q;
    if (clr_i) begin
      out_d = 1'b0;
    end else if (step_i) begin
      unique case (mode_use)
        OM_CLR_AT_CMP: begin
          if (hit_cmp)     out_d = 1'b0;
          else if (wrap_i) out_d = 1'b1;
        end
        OM_SET_AT_CMP: begin
          if (hit_cmp)     out_d = 1'b1;
          else if (wrap_i) out_d = 1'b0;
        end
        OM_TOGGLE: begin
          if (wrap_i && !per_zero_i) out_d = ~out_q;
        end
        default: out_d = out_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_sh_q   <= '0;
      mode_sh_q  <= OM_CLR_AT_CMP;
      cmp_act_q  <= '0;
      mode_act_q <= OM_CLR_AT_CMP;
      out_q      <= 1'b0;
    end else begin
      cmp_sh_q   <= cmp_sh_d;
      mode_sh_q  <= mode_sh_d;
      cmp_act_q  <= cmp_act_d;
      mode_act_q <= mode_act_d;
      out_q      <= out_d;
    end
  end

  assign pwm_o      = out_q;
  assign cmp_act_o  = cmp_act_q;
  assign mode_act_o = mode_act_q;

endmodule

// File: rtl/cmp_pwm_unit.sv
module cmp_pwm_unit #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              run_i,
  input  logic              per_we_i,
  input  logic [CNT_W-1:0]  per_data_i,
  input  logic [NUM_CH-1:0] cmp_we_i,
  input  logic [CNT_W-1:0]  cmp_data_i,
  input  logic [NUM_CH-1:0] mode_we_i,
  input  logic [1:0]        mode_data_i,
  output logic [NUM_CH-1:0] pwm_o
);

  logic [CNT_W-1:0]             cnt_w;
  logic [CNT_W-1:0]             cnt_nxt_w;
  logic [CNT_W-1:0]             per_w;
  logic                         step_w;
  logic                         wrap_w;
  logic                         per_zero_w;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act_w;
  logic [NUM_CH-1:0][1:0]       mode_act_w;

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .run_i      (run_i),
    .per_we_i   (per_we_i),
    .per_data_i (per_data_i),
    .cnt_o      (cnt_w),
    .cnt_nxt_o  (cnt_nxt_w),
    .per_o      (per_w),
    .step_o     (step_w),
    .wrap_o     (wrap_w),
    .per_zero_o (per_zero_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .clr_i       (clr_i),
      .step_i      (step_w),
      .wrap_i      (wrap_w),
      .per_zero_i  (per_zero_w),
      .cnt_nxt_i   (cnt_nxt_w),
      .cmp_we_i    (cmp_we_i[g]),
      .cmp_data_i  (cmp_data_i),
      .mode_we_i   (mode_we_i[g]),
      .mode_data_i (mode_data_i),
      .pwm_o       (pwm_o[g]),
      .cmp_act_o   (cmp_act_w[g]),
      .mode_act_o  (mode_act_w[g])
    );
  end

endmodule

// File: rtl/pwm_unit_chk.sv
module pwm_unit_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         clr_i,
  input logic                         run_i,
  input logic [CNT_W-1:0]             cnt_q,
  input logic [CNT_W-1:0]             per_q,
  input logic [NUM_CH-1:0]            pwm_o,
  input logic [NUM_CH-1:0][CNT_W-1:0] cmp_act,
  input logic [NUM_CH-1:0][1:0]       mode_act
);

  import pwm_pkg::*;

  AST_CLR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (pwm_o == '0) && (cnt_q == '0)); // R8

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !run_i) |=> ($stable(cnt_q) && $stable(pwm_o))); // R9

  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && (cnt_q < per_q)) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1

  AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !clr_i && (cnt_q >= per_q)) |=> (cnt_q == '0)); // R1

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    AST_CMP_CLEARS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(run_i && !clr_i) && (mode_act[g] == OM_CLR_AT_CMP) && (cnt_q == cmp_act[g]))
        |-> !pwm_o[g]); // R5

    AST_CMP_SETS_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(run_i && !clr_i) && (mode_act[g] == OM_SET_AT_CMP) && (cnt_q == cmp_act[g]))
        |-> pwm_o[g]); // R3
  end

endmodule

bind cmp_pwm_unit pwm_unit_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clr_i    (clr_i),
  .run_i    (run_i),
  .cnt_q    (cnt_w),
  .per_q    (per_w),
  .pwm_o    (pwm_o),
  .cmp_act  (cmp_act_w),
  .mode_act (mode_act_w)
);

// File: tb/test_cmp_pwm_unit.sv
module test_cmp_pwm_unit;

  localparam int CW  = 16;
  localparam int NCH = 2;

  logic           clk_i = 1'b0;
  logic           rst_ni;
  logic           clr_i, run_i, per_we_i;
  logic [CW-1:0]  per_data_i, cmp_data_i;
  logic [NCH-1:0] cmp_we_i, mode_we_i;
  logic [1:0]     mode_data_i;
  logic [NCH-1:0] pwm_o;

  always #4 clk_i = ~clk_i;

  cmp_pwm_unit #(.CNT_W(CW), .NUM_CH(NCH)) i_cmp_pwm_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i), .run_i(run_i),
    .per_we_i(per_we_i), .per_data_i(per_data_i),
    .cmp_we_i(cmp_we_i), .cmp_data_i(cmp_data_i),
    .mode_we_i(mode_we_i), .mode_data_i(mode_data_i),
    .pwm_o(pwm_o)
  );

  typedef struct { logic [NCH-1:0] pwm; string req; } exp_t;
  exp_t q[$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string cur_req = "R8";

  // reference state built from the requirements
  int m_cnt, m_per;
  int m_csh[NCH], m_cact[NCH], m_msh[NCH], m_mact[NCH];
  bit m_out[NCH];

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per clock
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (pwm_o !== e.pwm) begin
          n_fail++;
          $display("FAIL %s scoreboard actual=%b expected=%b", e.req, pwm_o, e.pwm);
        end
      end
    end
  end

  // driver: one clock with current inputs, model pushes expected outputs
  task automatic step(bit clr, bit run);
    exp_t e;
    bit wrap;
    int nxt;
    clr_i = clr;
    run_i = run;
    wrap = run && !clr && (m_cnt >= m_per);
    nxt = clr ? 0 : (run ? (wrap ? 0 : m_cnt + 1) : m_cnt);
    for (int c = 0; c < NCH; c++) begin
      int cu, mu;
      cu = wrap ? m_csh[c] : m_cact[c];
      mu = wrap ? m_msh[c] : m_mact[c];
      if (clr) m_out[c] = 1'b0;
      else if (run) begin
        if (mu == 0) begin
          if (nxt == cu) m_out[c] = 1'b0; else if (wrap) m_out[c] = 1'b1;
        end else if (mu == 1) begin
          if (nxt == cu) m_out[c] = 1'b1; else if (wrap) m_out[c] = 1'b0;
        end else if (mu == 2) begin
          if (wrap && m_per != 0) m_out[c] = ~m_out[c];
        end
      end
      if (clr || wrap) begin m_cact[c] = m_csh[c]; m_mact[c] = m_msh[c]; end
      if (cmp_we_i[c])  m_csh[c] = int'(cmp_data_i);
      if (mode_we_i[c]) m_msh[c] = int'(mode_data_i);
    end
    if (per_we_i) m_per = int'(per_data_i);
    m_cnt = nxt;
    for (int c = 0; c < NCH; c++) e.pwm[c] = m_out[c];
    e.req = cur_req;
    q.push_back(e);
    @(posedge clk_i);
    @(negedge clk_i);
    per_we_i = 1'b0;
    cmp_we_i = '0;
    mode_we_i = '0;
  endtask

  task automatic set_ch(int c, int cmp, int mode, bit run);
    cmp_we_i[c] = 1'b1; mode_we_i[c] = 1'b1;
    cmp_data_i = CW'(cmp); mode_data_i = 2'(mode);
    step(1'b0, run);
  endtask

  task automatic set_per(int p, bit run);
    per_we_i = 1'b1; per_data_i = CW'(p);
    step(1'b0, run);
  endtask

  task automatic to_zero();
    step(1'b0, 1'b1);
    while (m_cnt != 0) step(1'b0, 1'b1);
  endtask

  task automatic count_hi(int n, output int h0, output int h1);
    h0 = 0; h1 = 0;
    for (int i = 0; i < n; i++) begin
      step(1'b0, 1'b1);
      h0 += int'(pwm_o[0]);
      h1 += int'(pwm_o[1]);
    end
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h0, h1;
    logic hold_lvl;
    rst_ni = 1'b0; clr_i = 1'b0; run_i = 1'b0; per_we_i = 1'b0;
    per_data_i = '0; cmp_data_i = '0; cmp_we_i = '0; mode_we_i = '0; mode_data_i = '0;
    m_cnt = 0; m_per = 0;
    for (int c = 0; c < NCH; c++) begin
      m_csh[c] = 0; m_cact[c] = 0; m_msh[c] = 0; m_mact[c] = 0; m_out[c] = 1'b0;
    end
    repeat (3) @(negedge clk_i);
    check(pwm_o == '0, "R8", int'(pwm_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 / R3: P=9, M=3, high-first on ch0, low-first on ch1
    cur_req = "R2";
    set_per(9, 1'b0);
    set_ch(0, 3, 0, 1'b0);
    set_ch(1, 3, 1, 1'b0);
    step(1'b1, 1'b0);
    check(pwm_o == '0, "R8", int'(pwm_o), 0);
    repeat (10) step(1'b0, 1'b1);
    count_hi(10, h0, h1);
    check(h0 == 3, "R2", h0, 3);
    check(h1 == 7, "R3", h1, 7);

    // R7: mid-period write is staged
    cur_req = "R7";
    step(1'b0, 1'b1);
    set_ch(0, 5, 0, 1'b1);
    step(1'b0, 1'b1);
    check(pwm_o[0] == 1'b0, "R7", int'(pwm_o[0]), 0);
    to_zero();
    count_hi(10, h0, h1);
    check(h0 == 5, "R7", h0, 5);

    // R4: compare above period
    cur_req = "R4";
    set_ch(0, 10, 0, 1'b1);
    set_ch(1, 12, 1, 1'b1);
    to_zero();
    count_hi(20, h0, h1);
    check(h0 == 20, "R4", h0, 20);
    check(h1 == 0, "R4", h1, 0);

    // R5: compare zero, compare event wins
    cur_req = "R5";
    set_ch(0, 0, 0, 1'b1);
    set_ch(1, 0, 1, 1'b1);
    to_zero();
    count_hi(20, h0, h1);
    check(h0 == 0, "R5", h0, 0);
    check(h1 == 20, "R5", h1, 20);

    // R6: toggle
    cur_req = "R6";
    set_ch(0, 3, 2, 1'b1);
    to_zero();
    hold_lvl = pwm_o[0];
    count_hi(40, h0, h1);
    check(h0 == 20, "R6", h0, 20);
    repeat (10) step(1'b0, 1'b1);
    check(pwm_o[0] != hold_lvl, "R6", int'(pwm_o[0]), int'(!hold_lvl));

    // R9: run low holds
    cur_req = "R9";
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    hold_lvl = pwm_o[0];
    repeat (6) step(1'b0, 1'b0);
    check(pwm_o[0] == hold_lvl, "R9", int'(pwm_o[0]), int'(hold_lvl));

    // R1: period P+1 with P=4, M=1 high-first
    cur_req = "R1";
    set_ch(0, 1, 0, 1'b1);
    set_per(4, 1'b1);
    to_zero();
    count_hi(15, h0, h1);
    check(h0 == 3, "R1", h0, 3);

    // R10: period zero
    cur_req = "R10";
    set_ch(0, 4, 0, 1'b1);
    set_ch(1, 0, 1, 1'b1);
    set_per(0, 1'b1);
    step(1'b0, 1'b1); step(1'b0, 1'b1);
    count_hi(10, h0, h1);
    check(h0 == 10, "R10", h0, 10);
    check(h1 == 10, "R10", h1, 10);
    set_ch(1, 3, 1, 1'b1);
    step(1'b0, 1'b1);
    count_hi(10, h0, h1);
    check(h1 == 0, "R10", h1, 0);
    set_ch(0, 0, 2, 1'b1);
    step(1'b0, 1'b1);
    hold_lvl = pwm_o[0];
    count_hi(10, h0, h1);
    check(h0 == (hold_lvl ? 10 : 0), "R10", h0, hold_lvl ? 10 : 0);
    set_ch(0, 0, 0, 1'b1);
    step(1'b0, 1'b1);
    count_hi(10, h0, h1);
    check(h0 == 0, "R10", h0, 0);

    // R8: clear while running
    cur_req = "R8";
    set_per(9, 1'b1);
    set_ch(0, 20, 0, 1'b1);
    to_zero();
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    check(pwm_o == '0, "R8", int'(pwm_o), 0);

    repeat (3) @(negedge clk_i);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule